// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire management bus of external Ethernet PHYs. Software programs two 32-bit registers. The data register is loaded first. A write to the command register with the go flag set then starts the transfer. The block generates the management clock from the system clock, shifts a complete management frame onto the data line, and releases the line when the PHY has to answer. On a read it places the 16 bits the PHY returns in the low half of the data register. The go flag stays set until the whole transaction has ended.

A single command can produce a short-form (Clause 22) frame or a long-form (Clause 45) sequence. In the long form the block first sends an address frame that carries the 16-bit register address from the upper half of the data register, and then sends the read or write frame. The pin is bidirectional on the board. The block presents it as an output, an output enable and an input, so the pad cell stays outside the block.

Register writes are plain single-cycle strobes. The block accepts one in any cycle and applies no back-pressure. While a transaction runs, the block drops writes to either register. Software learns that the block is free by polling bit 0 of the command register.

Top module: `mdio_master`

## Requirements
- R1: After reset both registers read 0x00000000, MDC is low and the MDIO output enable is low.
- R2: The command word fields are: bit 0 go/busy, bit 1 long-form select, bits 3:2 operation (01 write, 11 read), bits 10:8 clock select, bits 20:16 register or device number, bits 25:21 PHY number. All other bits read as zero. A command write with bit 0 set and operation 01 or 11 starts a transaction. Bit 0 then reads 1 until the transaction ends, and reads 0 after that.
- R3: A short-form frame, sent most significant bit first, is: 32 ones, start 01, opcode (01 write, 10 read), the 5-bit PHY number, the 5-bit register number, turnaround 10, and then 16 data bits. A write takes its data bits from data register bits 15:0. The data line changes only at falling MDC edges.
- R4: On a read the output enable is low for the last 18 bits (turnaround and data). The block samples MDIO on rising MDC edges and stores the 16 returned bits in data register bits 15:0, with bits 31:16 kept unchanged.
- R5: When bit 1 is set, the block sends two frames, each with start 00. The first is an address frame with opcode 00, the device number in the register field, and data taken from data register bits 31:16. The second has opcode 01 (write, with data register bits 15:0 as data) or opcode 11 (read).
- R6: MDC is low while the bus is idle. Each MDC half period lasts DIV_BASE << clock-select system clock cycles. A frame lasts 64 MDC periods.
- R7: While bit 0 reads 1, writes to the command register and to the data register have no effect.
- R8: A command write with bit 0 clear, or with an operation of 00 or 10, stores its fields but starts nothing, and bit 0 reads 0.
- R9: The MDIO output enable is low whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | Write target: 0 command register, 1 data register |
| reg_wdata | input | 32 | Write value |
| cmd_reg_o | output | 32 | Command register readback, busy in bit 0 |
| data_reg_o | output | 32 | Data register readback, including read results |
| mdc_o | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe_o | output | 1 | MDIO output enable, high to drive the pad |

## Verification
A bit counter or shift register that slips by even one position shows up at the pads within a single frame. The frame on the data line no longer matches 32 ones followed by the expected header, or the output enable drops at the wrong bit. A sequencer that gets stuck in the wrong phase shows up as a missing or extra second frame on a long-form access, or as a busy flag that clears too early or never clears. A wrong divider state shows up within two MDC edges as a wrong MDC period. A bad read capture shows up in the data register as soon as busy clears.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W   = 5;
  localparam int REG_W   = 5;
  localparam int SEL_W   = 3;
  localparam int PRE_W   = 32;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = PRE_W + 2 + 2 + PHY_W + REG_W + 2 + DATA_W;
  localparam int HDR_W   = PRE_W + 2 + 2 + PHY_W + REG_W;

  localparam int BIT_GO  = 0;
  localparam int BIT_LF  = 1;
  localparam int OP_LSB  = 2;
  localparam int SEL_LSB = 8;
  localparam int REG_LSB = 16;
  localparam int PHY_LSB = 21;

  typedef enum logic [1:0] { SEQ_IDLE, SEQ_ADDR, SEQ_MAIN } seq_e;

  typedef struct packed {
    logic [PHY_W-1:0] phy;
    logic [REG_W-1:0] regad;
    logic [SEL_W-1:0] csel;
    logic [1:0]       op;
    logic             lf;
  } cmd_t;

  function automatic logic [FRAME_W-1:0] mk_frame(
    input logic [1:0]        st,
    input logic [1:0]        op,
    input logic [PHY_W-1:0]  phy,
    input logic [REG_W-1:0]  ra,
    input logic [DATA_W-1:0] d
  );
    return {{PRE_W{1'b1}}, st, op, phy, ra, 2'b10, d};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_BASE = 2,
  parameter int SEL_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int MAX_HALF = DIV_BASE << ((1 << SEL_W) - 1);
  localparam int CNT_W    = $clog2(MAX_HALF) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;
  logic             tick;

  assign last = (CNT_W'(DIV_BASE) << sel) - CNT_W'(1);
  assign tick = en && (cnt_q == last);
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (!en) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R6: MDC only rises while the divider runs
  p_mdc_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(en));
  // R6: MDC returns low once stopped
  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame,
  input  logic               rd_frame,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               active,
  output logic               done,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int IDX_W = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] HDR_IDX  = IDX_W'(HDR_W);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(FRAME_W - DATA_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [IDX_W-1:0]   idx_q;
  logic               rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q   <= frame;
        idx_q  <= '0;
        rd_q   <= rd_frame;
        active <= 1'b1;
      end else if (active) begin
        if (rise && idx_q >= DAT_IDX)
          rd_data <= {rd_data[DATA_W-2:0], mdio_i};
        if (fall) begin
          if (idx_q == LAST_IDX) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      end
    end
  end

  assign mdio_o  = sh_q[FRAME_W-1];
  assign mdio_oe = active && !(rd_q && idx_q >= HDR_IDX);

  // R2: a new frame is only kicked while the engine is idle
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
  // R3: completion is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_BASE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_reg_o,
  output logic [31:0] data_reg_o,
  output logic        mdc_o,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe_o
);
  cmd_t               cmd_q, cmd_in;
  seq_e               seq_q;
  logic               busy_q, kick_q;
  logic [31:0]        data_q;
  logic               cmd_wr_ok, data_wr_ok, launch;
  logic [1:0]         f_st, f_op;
  logic [DATA_W-1:0]  f_data;
  logic [FRAME_W-1:0] frame;
  logic               rd_frame;
  logic               eng_active, eng_done, rise, fall;
  logic [DATA_W-1:0]  eng_rd;

  assign cmd_in.phy   = reg_wdata[PHY_LSB +: PHY_W];
  assign cmd_in.regad = reg_wdata[REG_LSB +: REG_W];
  assign cmd_in.csel  = reg_wdata[SEL_LSB +: SEL_W];
  assign cmd_in.op    = reg_wdata[OP_LSB +: 2];
  assign cmd_in.lf    = reg_wdata[BIT_LF];

  assign cmd_wr_ok  = reg_we && !reg_sel && !busy_q;
  assign data_wr_ok = reg_we && reg_sel && !busy_q;
  assign launch     = cmd_wr_ok && reg_wdata[BIT_GO] && cmd_in.op[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      seq_q  <= SEQ_IDLE;
      busy_q <= 1'b0;
      kick_q <= 1'b0;
      data_q <= '0;
    end else begin
      kick_q <= 1'b0;
      if (cmd_wr_ok) begin
        cmd_q <= cmd_in;
        if (launch) begin
          busy_q <= 1'b1;
          kick_q <= 1'b1;
          seq_q  <= cmd_in.lf ? SEQ_ADDR : SEQ_MAIN;
        end
      end
      if (data_wr_ok) data_q <= reg_wdata;
      if (eng_done) begin
        if (seq_q == SEQ_ADDR) begin
          seq_q  <= SEQ_MAIN;
          kick_q <= 1'b1;
        end else begin
          seq_q  <= SEQ_IDLE;
          busy_q <= 1'b0;
          if (cmd_q.op[1]) data_q[DATA_W-1:0] <= eng_rd;
        end
      end
    end
  end

  always_comb begin
    f_st = cmd_q.lf ? 2'b00 : 2'b01;
    if (seq_q == SEQ_ADDR) begin
      f_op   = 2'b00;
      f_data = data_q[31:16];
    end else begin
      f_data = data_q[DATA_W-1:0];
      if (cmd_q.lf) f_op = cmd_q.op;
      else          f_op = cmd_q.op[1] ? 2'b10 : 2'b01;
    end
  end

  assign frame    = mk_frame(f_st, f_op, cmd_q.phy, cmd_q.regad, f_data);
  assign rd_frame = (seq_q == SEQ_MAIN) && cmd_q.op[1];

  mdio_clkgen #(.DIV_BASE(DIV_BASE), .SEL_W(SEL_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en(eng_active), .sel(cmd_q.csel),
    .mdc(mdc_o), .rise(rise), .fall(fall)
  );

  mdio_frame_eng eng_i (
    .clk(clk), .rst_n(rst_n), .start(kick_q), .frame(frame),
    .rd_frame(rd_frame), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .active(eng_active), .done(eng_done), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe_o), .rd_data(eng_rd)
  );

  always_comb begin
    cmd_reg_o = '0;
    cmd_reg_o[BIT_GO]               = busy_q;
    cmd_reg_o[BIT_LF]               = cmd_q.lf;
    cmd_reg_o[OP_LSB +: 2]          = cmd_q.op;
    cmd_reg_o[SEL_LSB +: SEL_W]     = cmd_q.csel;
    cmd_reg_o[REG_LSB +: REG_W]     = cmd_q.regad;
    cmd_reg_o[PHY_LSB +: PHY_W]     = cmd_q.phy;
  end
  assign data_reg_o = data_q;

  // R7: command fields hold when written during a transaction
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we && !reg_sel) |=> $stable(cmd_q));
  // R7: upper data half holds when written during a transaction
  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && reg_we && reg_sel) |=> $stable(data_q[31:16]));
  // R9: pin released while idle
  p_idle_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdio_oe_o);
  // R2: busy ends only on a finished frame
  p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(eng_done));
endmodule

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;
  localparam int CLK_P = 10;
  localparam logic [63:0] M_WR = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] M_RD = 64'hFFFF_FFFF_FFFC_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_reg_o, data_reg_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  int checks = 0, failures = 0, frames_seen = 0, k = 0;
  logic [63:0] exp_bits_q[$];
  logic [63:0] exp_mask_q[$];
  logic [63:0] got_bits, got_mask;
  logic [15:0] phy_rd = '0;

  always #(CLK_P/2) clk = ~clk;

  mdio_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_reg_o(cmd_reg_o), .data_reg_o(data_reg_o),
    .mdc_o(mdc_o), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] mkf(input logic [1:0] st, input logic [1:0] op,
                                      input logic [4:0] phy, input logic [4:0] ra,
                                      input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, phy, ra, 2'b10, d};
  endfunction

  function automatic logic [31:0] cmdw(input logic [4:0] phy, input logic [4:0] ra,
                                       input logic [2:0] sel, input logic [1:0] op,
                                       input logic lf, input logic go);
    return {6'd0, phy, ra, 5'd0, sel, 4'd0, op, lf, go};
  endfunction

  task automatic reg_write(input logic sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_frame(input logic [63:0] b, input logic [63:0] m);
    exp_bits_q.push_back(b);
    exp_mask_q.push_back(m);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (cmd_reg_o[0] === 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Monitor: collect each 64-bit frame at rising MDC and score it (R3, R4, R5)
  initial begin
    forever begin
      @(posedge mdc_o);
      #1;
      got_bits = {got_bits[62:0], mdio_oe_o ? mdio_o : 1'b0};
      got_mask = {got_mask[62:0], mdio_oe_o};
      k++;
      if (k == 64) begin
        k = 0;
        frames_seen++;
        if (exp_bits_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R3 unexpected frame got=%h exp=none", got_bits);
        end else begin
          logic [63:0] eb, em;
          eb = exp_bits_q.pop_front();
          em = exp_mask_q.pop_front();
          check("R4 oe pattern", got_mask, em);
          check("R3/R5 frame bits", got_bits & em, eb & em);
        end
      end
    end
  end

  // PHY model: drive read data after each falling MDC edge
  initial begin
    forever begin
      @(negedge mdc_o);
      #1;
      if (k >= 48) mdio_i = phy_rd[63-k];
      else         mdio_i = 1'b1;
    end
  end

  initial begin
    #(CLK_P * 150000);
    checks++; failures++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    realtime t0;
    int fs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd", {32'd0, cmd_reg_o}, 64'd0);
    check("R1 data", {32'd0, data_reg_o}, 64'd0);
    check("R1 mdc/oe", {62'd0, mdc_o, mdio_oe_o}, 64'd0);

    // R3 short-form write, R6 period at select 0
    reg_write(1'b1, 32'h0000_A5C3);
    expect_frame(mkf(2'b01, 2'b01, 5'h11, 5'h0A, 16'hA5C3), M_WR);
    reg_write(1'b0, cmdw(5'h11, 5'h0A, 3'd0, 2'b01, 1'b0, 1'b1));
    check("R2 busy set", {63'd0, cmd_reg_o[0]}, 64'd1);
    @(posedge mdc_o); t0 = $realtime; @(posedge mdc_o);
    check("R6 period sel0", 64'(int'(($realtime - t0) / CLK_P)), 64'd4);
    wait_idle();
    check("R2 busy clear", {63'd0, cmd_reg_o[0]}, 64'd0);
    check("R2 cmd fields", {32'd0, cmd_reg_o}, {32'd0, cmdw(5'h11, 5'h0A, 3'd0, 2'b01, 1'b0, 1'b0)});
    check("R9 oe idle", {63'd0, mdio_oe_o}, 64'd0);

    // R4 short-form read, R6 period at select 1
    reg_write(1'b1, 32'h1234_0000);
    phy_rd = 16'hBEEF;
    expect_frame(mkf(2'b01, 2'b10, 5'h03, 5'h01, 16'hBEEF), M_RD);
    reg_write(1'b0, cmdw(5'h03, 5'h01, 3'd1, 2'b11, 1'b0, 1'b1));
    @(posedge mdc_o); t0 = $realtime; @(posedge mdc_o);
    check("R6 period sel1", 64'(int'(($realtime - t0) / CLK_P)), 64'd8);
    wait_idle();
    check("R4 read data", {32'd0, data_reg_o}, {32'd0, 32'h1234_BEEF});

    // R5 long-form write, R7 writes during busy ignored
    reg_write(1'b1, 32'h8001_5A5A);
    expect_frame(mkf(2'b00, 2'b00, 5'h07, 5'h03, 16'h8001), M_WR);
    expect_frame(mkf(2'b00, 2'b01, 5'h07, 5'h03, 16'h5A5A), M_WR);
    reg_write(1'b0, cmdw(5'h07, 5'h03, 3'd0, 2'b01, 1'b1, 1'b1));
    repeat (100) @(negedge clk);
    reg_write(1'b0, cmdw(5'h1C, 5'h15, 3'd5, 2'b11, 1'b0, 1'b1));
    check("R7 cmd ignored", {32'd0, cmd_reg_o}, {32'd0, cmdw(5'h07, 5'h03, 3'd0, 2'b01, 1'b1, 1'b1)});
    reg_write(1'b1, 32'hFFFF_FFFF);
    check("R7 data ignored", {32'd0, data_reg_o}, {32'd0, 32'h8001_5A5A});
    wait_idle();
    check("R7 data after", {32'd0, data_reg_o}, {32'd0, 32'h8001_5A5A});
    check("R5 two frames", 64'(frames_seen), 64'd4);

    // R5 long-form read
    reg_write(1'b1, 32'h0042_0000);
    phy_rd = 16'hC0DE;
    expect_frame(mkf(2'b00, 2'b00, 5'h1F, 5'h1F, 16'h0042), M_WR);
    expect_frame(mkf(2'b00, 2'b11, 5'h1F, 5'h1F, 16'hC0DE), M_RD);
    reg_write(1'b0, cmdw(5'h1F, 5'h1F, 3'd0, 2'b11, 1'b1, 1'b1));
    wait_idle();
    check("R5 read data", {32'd0, data_reg_o}, {32'd0, 32'h0042_C0DE});

    // R8 commands that start nothing
    fs = frames_seen;
    reg_write(1'b0, cmdw(5'h02, 5'h04, 3'd0, 2'b01, 1'b0, 1'b0));
    check("R8 go clear stored", {32'd0, cmd_reg_o}, {32'd0, cmdw(5'h02, 5'h04, 3'd0, 2'b01, 1'b0, 1'b0)});
    reg_write(1'b0, cmdw(5'h02, 5'h04, 3'd0, 2'b10, 1'b0, 1'b1));
    check("R8 bad op busy", {63'd0, cmd_reg_o[0]}, 64'd0);
    repeat (40) @(negedge clk);
    check("R8 no mdc", {63'd0, mdc_o}, 64'd0);
    check("R9 oe low", {63'd0, mdio_oe_o}, 64'd0);
    check("R8 no frame", 64'(frames_seen), 64'(fs));
    check("R3 queue drained", 64'(exp_bits_q.size()), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule